// File: doc/BRIEF.md
# GPIO Pin Controller with Interrupt Detection

This block is the control and status word for a single general-purpose I/O pin. Software reaches it through a one-word write port and a read port that is always valid. The word holds the pad settings: input enable, Schmitt enable, a two-bit drive strength, pull-up, pull-down and output enable. These settings go straight to the pad. It also holds a five-bit selector that is passed out to an external peripheral mux.

The pad output value comes from an internal output register. That register is loaded in one of four pin modes, set by bits 31:30. Mode 0 (PM_DIRECT) drives the register straight from bit 24 of each write. Mode 1 (PM_STROBE) changes the register only through the write-one strobes at bit 25 (set) and bit 26 (clear). Mode 2 (PM_DMA_DIRECT) drives the pad from the DMA level input, and bit 24 is still stored. Mode 3 (PM_DMA_STROBE) changes the register from the DMA set and clear inputs. In every strobe form, set wins over clear. A bus write is decoded under the pin mode carried in the same word.

The interrupt detector watches the pad input. It runs in a synchronous family of modes, which use a two-flop synchronizer, and in an asynchronous family, which uses a single capture flop. A two-state machine holds the sticky interrupt flag. In IRQ_IDLE it moves to IRQ_PEND when the selected condition is seen and no clear is active ("detect"). In IRQ_PEND it moves back to IRQ_IDLE when the delayed clear pulse arrives ("clear"). In any other case it stays where it is. The clear takes priority, so a level that is still present sets the flag again one cycle later.

Top module: `gpin_unit`

## Requirements
- R1: After reset, bus_rdata reads 0, every pad control output reads 0, pad_out reads 0 and irq reads 0.
- R2: The stored fields read back as written: bit 0 input enable, bit 1 Schmitt, bits 3:2 drive, bit 4 pull-up, bit 5 pull-down, bit 6 output enable, bits 12:8 mux selector, bits 19:16 interrupt mode, bit 22 mask, bits 31:30 pin mode. Each of them drives its pad or selector output.
- R3: In pin mode 0, bit 24 of a write appears on pad_out and on read bit 24 after the write's clock edge, and it holds while there are no writes.
- R4: In pin mode 1, a write with bit 25 set makes the output 1, and a write with bit 26 set makes it 0. If both are set, the output is 1. Bit 24 of such a write is ignored. Bits 25 and 26 always read 0.
- R5: In pin mode 2, pad_out follows dma_level combinationally. Bit 24 of a write is still stored and read back.
- R6: In pin mode 3, each clock edge with dma_set high makes the output 1, and one with only dma_clr high makes it 0. Both high gives 1, and neither holds the value.
- R7: Mode codes 0 to 4 detect falling edge, rising edge, low level, high level and either edge on the synchronized input. Read bit 21 and irq rise on the third clock edge after the pad change.
- R8: Mode codes 8 to 11 detect falling edge, rising edge, low level and high level with one cycle less latency: on the second edge after the pad change.
- R9: The flag in bit 21 stays set after the condition goes away. Writing bit 20 makes bit 20 read 1 for one cycle and clears the flag on the next edge. A level that is still present sets the flag again one edge after that.
- R10: irq equals flag AND NOT mask (bit 22). Bit 21 still shows the flag while it is masked.
- R11: Mode codes 5 to 7 and 12 to 15 never set the flag, whatever the pad does.
- R12: Read bit 28 returns the synchronized pad input when input enable is 1, two edges after the pad change, and returns 0 when input enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always valid |
| pad_in | input | 1 | Pad input level |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |
| pad_ie | output | 1 | Pad input enable |
| pad_schmitt | output | 1 | Schmitt trigger enable |
| pad_drive | output | 2 | Drive strength code |
| pad_pull_up | output | 1 | Pull-up enable |
| pad_pull_down | output | 1 | Pull-down enable |
| alt_sel | output | 5 | Selector for the external peripheral mux |
| dma_level | input | 1 | DMA output level used in pin mode 2 |
| dma_set | input | 1 | DMA set command used in pin mode 3 |
| dma_clr | input | 1 | DMA clear command used in pin mode 3 |
| irq | output | 1 | Pin interrupt request |

## Verification
A flag state machine stuck in IRQ_PEND shows up in read bit 21 on the edge right after a clear pulse. A missed transition into IRQ_PEND shows up on irq at the exact expected edge, because every interrupt check samples one cycle before and one cycle at the expected latency. A wrong synchronizer depth or a wrong asynchronous bypass therefore moves the flag by one edge and is caught. A corrupted output register or a wrong mode decode appears on pad_out one edge after the write or DMA strobe that exposed it.

// File: rtl/gpin_pkg.sv
package gpin_pkg;

    localparam int REG_W   = 32;
    localparam int DRV_W   = 2;
    localparam int ALT_W   = 5;
    localparam int IMODE_W = 4;
    localparam int PMODE_W = 2;

    // bit positions in the control word (software decodes these)
    localparam int F_IE     = 0;
    localparam int F_SMT    = 1;
    localparam int F_DRV    = 2;
    localparam int F_PU     = 4;
    localparam int F_PD     = 5;
    localparam int F_OE     = 6;
    localparam int F_ALT    = 8;
    localparam int F_IMODE  = 16;
    localparam int F_ICLR   = 20;
    localparam int F_ISTATE = 21;
    localparam int F_IMASK  = 22;
    localparam int F_OVAL   = 24;
    localparam int F_OSET   = 25;
    localparam int F_OCLR   = 26;
    localparam int F_IVAL   = 28;
    localparam int F_PMODE  = 30;

    // interrupt mode codes
    localparam logic [IMODE_W-1:0] IM_S_FALL = 4'd0;
    localparam logic [IMODE_W-1:0] IM_S_RISE = 4'd1;
    localparam logic [IMODE_W-1:0] IM_S_LOW  = 4'd2;
    localparam logic [IMODE_W-1:0] IM_S_HIGH = 4'd3;
    localparam logic [IMODE_W-1:0] IM_S_BOTH = 4'd4;
    localparam logic [IMODE_W-1:0] IM_A_FALL = 4'd8;
    localparam logic [IMODE_W-1:0] IM_A_RISE = 4'd9;
    localparam logic [IMODE_W-1:0] IM_A_LOW  = 4'd10;
    localparam logic [IMODE_W-1:0] IM_A_HIGH = 4'd11;

    typedef enum logic [PMODE_W-1:0] {
        PM_DIRECT     = 2'd0,
        PM_STROBE     = 2'd1,
        PM_DMA_DIRECT = 2'd2,
        PM_DMA_STROBE = 2'd3
    } pin_mode_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic                ie;
        logic                smt;
        logic [DRV_W-1:0]    drv;
        logic                pu;
        logic                pd;
        logic                oe;
        logic [ALT_W-1:0]    alt;
        logic [IMODE_W-1:0]  imode;
        logic                imask;
        pin_mode_e           pmode;
    } pin_cfg_t;

endpackage

// File: rtl/gpin_cfg_regs.sv
module gpin_cfg_regs
    import gpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output pin_cfg_t         cfg,
    output logic             clr_pulse
);

    // bits held elsewhere or reserved
    logic unused_wbits;
    assign unused_wbits = ^{wdata[7], wdata[15:13], wdata[F_ISTATE], wdata[23],
                            wdata[29:24]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.ie    <= wdata[F_IE];
            cfg.smt   <= wdata[F_SMT];
            cfg.drv   <= wdata[F_DRV +: DRV_W];
            cfg.pu    <= wdata[F_PU];
            cfg.pd    <= wdata[F_PD];
            cfg.oe    <= wdata[F_OE];
            cfg.alt   <= wdata[F_ALT +: ALT_W];
            cfg.imode <= wdata[F_IMODE +: IMODE_W];
            cfg.imask <= wdata[F_IMASK];
            cfg.pmode <= pin_mode_e'(wdata[F_PMODE +: PMODE_W]);
        end
    end

    // interrupt clear: one-cycle pulse, acts on the following edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= wr_en & wdata[F_ICLR];
        end
    end

endmodule

// File: rtl/gpin_out_path.sv
module gpin_out_path
    import gpin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  pin_mode_e wr_mode,
    input  logic      wr_val,
    input  logic      wr_set,
    input  logic      wr_clr,
    input  pin_mode_e cur_mode,
    input  logic      dma_level,
    input  logic      dma_set,
    input  logic      dma_clr,
    output logic      out_q,
    output logic      pad_out
);

    pin_mode_e eff_mode;
    logic      out_d;

    // a write is decoded under the mode carried in the same word
    assign eff_mode = wr_en ? wr_mode : cur_mode;

    always_comb begin
        out_d = out_q;
        unique case (eff_mode)
            PM_DIRECT, PM_DMA_DIRECT: begin
                if (wr_en) out_d = wr_val;
            end
            PM_STROBE: begin
                if (wr_en) begin
                    if (wr_set)      out_d = 1'b1;
                    else if (wr_clr) out_d = 1'b0;
                end
            end
            PM_DMA_STROBE: begin
                if (dma_set)      out_d = 1'b1;
                else if (dma_clr) out_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    always_comb begin
        unique case (cur_mode)
            PM_DMA_DIRECT: pad_out = dma_level;
            default:       pad_out = out_q;
        endcase
    end

    assert_bus_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == PM_STROBE && wr_set) |=> out_q);

    assert_dma_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == PM_DMA_STROBE && dma_set) |=> out_q);

    assert_direct_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cur_mode == PM_DIRECT) |=> $stable(out_q));

endmodule

// File: rtl/gpin_irq_detect.sv
module gpin_irq_detect
    import gpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pad_in,
    input  logic [IMODE_W-1:0] imode,
    input  logic               clr,
    output logic               pend,
    output logic               sync_level
);

    logic [SYNC_STAGES-1:0] sync_sh;
    logic                   sync_now;
    logic                   sync_prev;
    logic                   raw_now;
    logic                   raw_prev;
    logic                   hit;
    irq_state_e             state_q;
    irq_state_e             state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sh <= '0;
                else        sync_sh <= pad_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sh <= '0;
                else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], pad_in};
            end
        end
    endgenerate

    assign sync_now   = sync_sh[SYNC_STAGES-1];
    assign sync_level = sync_now;

    // history flops: synchronized path and single-capture path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev <= 1'b0;
            raw_now   <= 1'b0;
            raw_prev  <= 1'b0;
        end else begin
            sync_prev <= sync_now;
            raw_now   <= pad_in;
            raw_prev  <= raw_now;
        end
    end

    always_comb begin
        unique case (imode)
            IM_S_FALL: hit = sync_prev & ~sync_now;
            IM_S_RISE: hit = ~sync_prev & sync_now;
            IM_S_LOW:  hit = ~sync_now;
            IM_S_HIGH: hit = sync_now;
            IM_S_BOTH: hit = sync_prev ^ sync_now;
            IM_A_FALL: hit = raw_prev & ~raw_now;
            IM_A_RISE: hit = ~raw_prev & raw_now;
            IM_A_LOW:  hit = ~raw_now;
            IM_A_HIGH: hit = raw_now;
            default:   hit = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // transitions: detect (IDLE->PEND), clear (PEND->IDLE); clear has priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (!clr && hit) state_d = IRQ_PEND;
            IRQ_PEND: if (clr)         state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend = (state_q == IRQ_PEND);
    end

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PEND && !clr) |=> state_q == IRQ_PEND);

    assert_clear_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state_q == IRQ_IDLE);

    assert_undef_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!((imode <= IM_S_BOTH) || ((imode >= IM_A_FALL) && (imode <= IM_A_HIGH)))
         && state_q == IRQ_IDLE) |=> state_q == IRQ_IDLE);

endmodule

// File: rtl/gpin_unit.sv
module gpin_unit
    import gpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             pad_ie,
    output logic             pad_schmitt,
    output logic [DRV_W-1:0] pad_drive,
    output logic             pad_pull_up,
    output logic             pad_pull_down,
    output logic [ALT_W-1:0] alt_sel,
    input  logic             dma_level,
    input  logic             dma_set,
    input  logic             dma_clr,
    output logic             irq
);

    pin_cfg_t cfg;
    logic     clr_pulse;
    logic     out_q;
    logic     pend;
    logic     sync_level;

    gpin_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .wdata     (bus_wdata),
        .cfg       (cfg),
        .clr_pulse (clr_pulse)
    );

    gpin_out_path u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .wr_mode   (pin_mode_e'(bus_wdata[F_PMODE +: PMODE_W])),
        .wr_val    (bus_wdata[F_OVAL]),
        .wr_set    (bus_wdata[F_OSET]),
        .wr_clr    (bus_wdata[F_OCLR]),
        .cur_mode  (cfg.pmode),
        .dma_level (dma_level),
        .dma_set   (dma_set),
        .dma_clr   (dma_clr),
        .out_q     (out_q),
        .pad_out   (pad_out)
    );

    gpin_irq_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_in     (pad_in),
        .imode      (cfg.imode),
        .clr        (clr_pulse),
        .pend       (pend),
        .sync_level (sync_level)
    );

    assign pad_ie        = cfg.ie;
    assign pad_schmitt   = cfg.smt;
    assign pad_drive     = cfg.drv;
    assign pad_pull_up   = cfg.pu;
    assign pad_pull_down = cfg.pd;
    assign pad_oe        = cfg.oe;
    assign alt_sel       = cfg.alt;
    assign irq           = pend & ~cfg.imask;

    always_comb begin
        bus_rdata                         = '0;
        bus_rdata[F_IE]                   = cfg.ie;
        bus_rdata[F_SMT]                  = cfg.smt;
        bus_rdata[F_DRV +: DRV_W]         = cfg.drv;
        bus_rdata[F_PU]                   = cfg.pu;
        bus_rdata[F_PD]                   = cfg.pd;
        bus_rdata[F_OE]                   = cfg.oe;
        bus_rdata[F_ALT +: ALT_W]         = cfg.alt;
        bus_rdata[F_IMODE +: IMODE_W]     = cfg.imode;
        bus_rdata[F_ICLR]                 = clr_pulse;
        bus_rdata[F_ISTATE]               = pend;
        bus_rdata[F_IMASK]                = cfg.imask;
        bus_rdata[F_OVAL]                 = out_q;
        bus_rdata[F_IVAL]                 = sync_level & cfg.ie;
        bus_rdata[F_PMODE +: PMODE_W]     = cfg.pmode;
    end

endmodule

// File: tb/gpin_unit_bench.sv
module gpin_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        pad_in = 1'b0;
    logic        pad_out, pad_oe, pad_ie, pad_schmitt, pad_pull_up, pad_pull_down;
    logic [1:0]  pad_drive;
    logic [4:0]  alt_sel;
    logic        dma_level = 1'b0;
    logic        dma_set = 1'b0;
    logic        dma_clr = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpin_unit u_gpin_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pad_in        (pad_in),
        .pad_out       (pad_out),
        .pad_oe        (pad_oe),
        .pad_ie        (pad_ie),
        .pad_schmitt   (pad_schmitt),
        .pad_drive     (pad_drive),
        .pad_pull_up   (pad_pull_up),
        .pad_pull_down (pad_pull_down),
        .alt_sel       (alt_sel),
        .dma_level     (dma_level),
        .dma_set       (dma_set),
        .dma_clr       (dma_clr),
        .irq           (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        bus_we = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        bus_wdata = 32'h0;
    endtask

    // arm a mode, clear the flag, apply one pad change, check latency
    task automatic irq_case(input string req, input logic [3:0] mode, input logic lvl0,
                            input logic lvl1, input int lat, input logic fire);
        logic [31:0] cfg;
        cfg = 32'(mode) << 16;
        pad_in = lvl0;
        wr(cfg);
        tick(4);
        wr(cfg | 32'h0010_0000);
        tick(2);
        chk(req, "armed flag", 32'(bus_rdata[21]), 32'd0);
        pad_in = lvl1;
        if (fire) begin
            tick(lat - 1);
            chk(req, "flag one edge early", 32'(bus_rdata[21]), 32'd0);
            tick(1);
            chk(req, "flag at latency", 32'(bus_rdata[21]), 32'd1);
            chk(req, "irq at latency", 32'(irq), 32'd1);
        end else begin
            tick(4);
            chk(req, "no flag", 32'(bus_rdata[21]), 32'd0);
        end
    endtask

    task automatic t_reset_r1;
        chk("R1", "rdata", bus_rdata, 32'h0);
        chk("R1", "pad controls",
            32'({pad_out, pad_oe, pad_ie, pad_schmitt, pad_drive, pad_pull_up, pad_pull_down, alt_sel}),
            32'h0);
        chk("R1", "irq", 32'(irq), 32'd0);
    endtask

    task automatic t_fields_r2;
        wr(32'h8043_135B);
        chk("R2", "readback", bus_rdata, 32'h8043_135B);
        chk("R2", "pad outputs",
            32'({pad_ie, pad_schmitt, pad_drive, pad_pull_up, pad_pull_down, pad_oe}),
            32'b1_1_10_1_0_1);
        chk("R2", "alt_sel", 32'(alt_sel), 32'h13);
        wr(32'h0);
        chk("R2", "cleared", bus_rdata, 32'h0);
    endtask

    task automatic t_direct_r3;
        wr(32'h0100_0040);
        chk("R3", "pad_out high", 32'({pad_out, pad_oe}), 32'b11);
        chk("R3", "readback", bus_rdata, 32'h0100_0040);
        tick(3);
        chk("R3", "hold", 32'(pad_out), 32'd1);
        wr(32'h0);
        chk("R3", "pad_out low", 32'({pad_out, pad_oe}), 32'b00);
    endtask

    task automatic t_strobe_r4;
        wr(32'h4200_0000);
        chk("R4", "set", 32'(pad_out), 32'd1);
        chk("R4", "strobes read 0", bus_rdata, 32'h4100_0000);
        wr(32'h4000_0000);
        chk("R4", "no strobe holds", 32'(pad_out), 32'd1);
        wr(32'h4400_0000);
        chk("R4", "clear", 32'(pad_out), 32'd0);
        wr(32'h4100_0000);
        chk("R4", "value bit ignored", 32'(pad_out), 32'd0);
        wr(32'h4600_0000);
        chk("R4", "set wins", 32'(pad_out), 32'd1);
    endtask

    task automatic t_dma_direct_r5;
        wr(32'h8000_0000);
        dma_level = 1'b1;
        #1;
        chk("R5", "follow high", 32'(pad_out), 32'd1);
        dma_level = 1'b0;
        #1;
        chk("R5", "follow low", 32'(pad_out), 32'd0);
        wr(32'h8100_0000);
        chk("R5", "value stored", bus_rdata, 32'h8100_0000);
        chk("R5", "value not driven", 32'(pad_out), 32'd0);
        dma_level = 1'b1;
        #1;
        chk("R5", "follow again", 32'(pad_out), 32'd1);
        dma_level = 1'b0;
    endtask

    task automatic t_dma_strobe_r6;
        wr(32'hC000_0000);
        chk("R6", "entry keeps value", 32'(pad_out), 32'd1);
        dma_clr = 1'b1;
        tick(1);
        dma_clr = 1'b0;
        chk("R6", "dma clear", 32'(pad_out), 32'd0);
        chk("R6", "readback", bus_rdata, 32'hC000_0000);
        dma_set = 1'b1;
        dma_clr = 1'b1;
        tick(1);
        dma_set = 1'b0;
        dma_clr = 1'b0;
        chk("R6", "set wins", 32'(pad_out), 32'd1);
        tick(2);
        chk("R6", "hold", 32'(pad_out), 32'd1);
        dma_clr = 1'b1;
        tick(1);
        dma_clr = 1'b0;
        chk("R6", "clear again", 32'(pad_out), 32'd0);
        wr(32'h0);
    endtask

    task automatic t_sync_r7;
        irq_case("R7", 4'd0, 1'b1, 1'b0, 3, 1'b1);
        irq_case("R7", 4'd1, 1'b0, 1'b1, 3, 1'b1);
        irq_case("R7", 4'd2, 1'b1, 1'b0, 3, 1'b1);
        irq_case("R7", 4'd3, 1'b0, 1'b1, 3, 1'b1);
        irq_case("R7", 4'd4, 1'b0, 1'b1, 3, 1'b1);
        irq_case("R7", 4'd4, 1'b1, 1'b0, 3, 1'b1);
        irq_case("R7", 4'd1, 1'b1, 1'b0, 3, 1'b0);
    endtask

    task automatic t_async_r8;
        irq_case("R8", 4'd8,  1'b1, 1'b0, 2, 1'b1);
        irq_case("R8", 4'd9,  1'b0, 1'b1, 2, 1'b1);
        irq_case("R8", 4'd10, 1'b1, 1'b0, 2, 1'b1);
        irq_case("R8", 4'd11, 1'b0, 1'b1, 2, 1'b1);
    endtask

    task automatic t_sticky_r9;
        irq_case("R9", 4'd1, 1'b0, 1'b1, 3, 1'b1);
        pad_in = 1'b0;
        tick(4);
        chk("R9", "sticky", bus_rdata, 32'h0021_0000);
        wr(32'h0011_0000);
        chk("R9", "clear bit reads 1", bus_rdata, 32'h0031_0000);
        tick(1);
        chk("R9", "cleared", bus_rdata, 32'h0001_0000);
        irq_case("R9", 4'd3, 1'b0, 1'b1, 3, 1'b1);
        wr(32'h0013_0000);
        tick(1);
        chk("R9", "level cleared", bus_rdata, 32'h0003_0000);
        tick(1);
        chk("R9", "level re-set", bus_rdata, 32'h0023_0000);
        pad_in = 1'b0;
        tick(3);
    endtask

    task automatic t_mask_r10;
        pad_in = 1'b0;
        wr(32'h0043_0000);
        tick(4);
        wr(32'h0053_0000);
        tick(2);
        pad_in = 1'b1;
        tick(3);
        chk("R10", "masked flag visible", bus_rdata, 32'h0063_0000);
        chk("R10", "masked irq", 32'(irq), 32'd0);
        wr(32'h0003_0000);
        chk("R10", "unmasked irq", 32'(irq), 32'd1);
        pad_in = 1'b0;
        tick(3);
    endtask

    task automatic t_undef_r11(input logic [3:0] mode);
        pad_in = 1'b0;
        wr(32'(mode) << 16);
        wr((32'(mode) << 16) | 32'h0010_0000);
        tick(2);
        pad_in = 1'b1;
        tick(4);
        pad_in = 1'b0;
        tick(4);
        chk("R11", "undefined code quiet", 32'({bus_rdata[21], irq}), 32'd0);
    endtask

    task automatic t_input_r12;
        pad_in = 1'b0;
        wr(32'h0000_0001);
        tick(3);
        pad_in = 1'b1;
        tick(1);
        chk("R12", "one edge", 32'(bus_rdata[28]), 32'd0);
        tick(1);
        chk("R12", "two edges", 32'(bus_rdata[28]), 32'd1);
        wr(32'h0000_0000);
        chk("R12", "disabled reads 0", 32'(bus_rdata[28]), 32'd0);
        pad_in = 1'b0;
        tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset_r1();
        t_fields_r2();
        t_direct_r3();
        t_strobe_r4();
        t_dma_direct_r5();
        t_dma_strobe_r6();
        t_sync_r7();
        t_async_r8();
        t_sticky_r9();
        t_mask_r10();
        t_undef_r11(4'd5);
        t_undef_r11(4'd7);
        t_undef_r11(4'd12);
        t_undef_r11(4'd15);
        t_input_r12();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule